// File: doc/BRIEF.md
# Gated Asynchronous Serial Receiver

This block turns a single asynchronous serial line into parallel characters. The line passes through a two-flop synchroniser. A low level seen while reception is enabled starts a candidate start bit. The candidate is checked again half a bit period later and is then accepted or dropped. After that the receiver samples the line once per bit period, which places each sample at mid-bit. It collects 7 or 8 data bits, least significant first, then an optional parity bit, then one stop bit.

When the stop bit has been sampled, the assembled character is copied into a receive buffer. One clock-wide pulse then reports the result: a completion pulse for a clean frame, or an error pulse with parity, framing and overrun flags. The bit period is counted in baud ticks, which come from an external prescaler. The divider, data length and parity mode are static configuration inputs.

A single enable gates everything. Dropping the enable mid-frame abandons the frame at once and leaves the buffer, the flags and both pulses untouched. Raising the enable while the line is already low counts as a start condition.

Top module: `uart_rx_gated`

## Requirements
- R1: After reset, `rx_data` is 0, all three error flags are 0 and neither `rx_done` nor `rx_err` is high.
- R2: The line is synchronised by two flops. While enabled and idle, a low synchronised level starts a start-bit check. If the line is high again at the half-bit sample, taken after `div_val>>1` ticks, the receiver returns to idle with no pulse.
- R3: Once the start bit is accepted, each later sample comes after `div_val` baud ticks. The counter advances only on cycles with `baud_tick` high. Supported values of `div_val` are 8 to 31.
- R4: Data bits arrive least significant first. With `len7`=1, seven bits are received and `rx_data[7]` is 0. With `len7`=0, eight bits are received.
- R5: `par_mode` encodes the parity setting: 2'b01 is even parity, 2'b10 is odd parity, and 2'b00 or 2'b11 means no parity bit in the frame. Even parity requires an even count of ones across the data and parity bits. Odd parity requires an odd count.
- R6: At the stop-bit sample, the character is written to `rx_data`. A clean frame gives a `rx_done` pulse exactly one cycle wide.
- R7: A stop bit sampled low sets `err_frm`.
- R8: If a frame completes while the previous character is still unread, `err_ovr` is set. A pulse on `buf_read` marks the buffer as read. The new character still overwrites `rx_data`.
- R9: If any flag is set at completion, the frame gives `rx_err` in place of `rx_done`, never both. All three flags are rewritten at every completion, so a clean frame clears them.
- R10: Clearing `rx_en` mid-frame returns the receiver to idle at once. `rx_data`, the flags, `rx_done` and `rx_err` are then unaffected by that frame.
- R11: Setting `rx_en` while the line is already low starts reception immediately. A frame whose start bit began before the enable is then received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Reception enable; low forces idle |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| baud_tick | input | 1 | One-cycle tick from the baud prescaler |
| div_val | input | 5 | Bit period in baud ticks |
| len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| par_mode | input | 2 | 01 even, 10 odd, 00/11 no parity |
| buf_read | input | 1 | Marks the receive buffer as read |
| rx_data | output | 8 | Receive buffer |
| rx_done | output | 1 | Clean-frame completion pulse |
| rx_err | output | 1 | Error completion pulse |
| err_par | output | 1 | Parity error of last frame |
| err_frm | output | 1 | Framing error of last frame |
| err_ovr | output | 1 | Overrun at last frame |

## Verification
Full sweeps run over every 8-bit character with even parity, over every 7-bit character with odd parity, and over spread characters with no parity at the longest divider and with a slow tick. A receiver that reversed the bit order, misplaced the half-bit point or counted clock cycles instead of ticks would corrupt characters in these sweeps. A short low glitch must die at the half-bit check; a receiver that skipped that check would deliver a spurious frame. Aborting mid-frame after a framing error must keep the stale flags and buffer, and a two-frame overrun followed by a clean frame must show the flags being replaced. A frame whose start bit began before the enable must still arrive; an edge-triggered start would drop it.

// File: rtl/uart_rx_gated.sv
module uart_rx_gated #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          rx_in,
  input  logic          baud_tick,
  input  logic [CW-1:0] div_val,
  input  logic          len7,
  input  logic [1:0]    par_mode,
  input  logic          buf_read,
  output logic [7:0]    rx_data,
  output logic          rx_done,
  output logic          rx_err,
  output logic          err_par,
  output logic          err_frm,
  output logic          err_ovr
);
  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP} st_t;

  st_t           st;
  logic          s1, s2, full, pbit;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx;
  logic [7:0]    sh;

  wire [CW-1:0] tgt    = (st == START) ? (div_val >> 1) : div_val;
  wire          hit    = baud_tick && (cnt == tgt - 1'b1);
  wire          par_on = ^par_mode;
  wire [7:0]    word   = len7 ? {1'b0, sh[7:1]} : sh;
  wire          pe     = par_on && ((^word ^ pbit) != par_mode[1]);
  wire [2:0]    last   = len7 ? 3'd6 : 3'd7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; s1 <= 1'b1; s2 <= 1'b1; full <= 1'b0; pbit <= 1'b0;
      cnt <= '0; bidx <= '0; sh <= '0; rx_data <= '0;
      rx_done <= 1'b0; rx_err <= 1'b0;
      err_par <= 1'b0; err_frm <= 1'b0; err_ovr <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      rx_err  <= 1'b0;
      s1 <= rx_in;
      s2 <= s1;
      if (buf_read) full <= 1'b0;
      if (!rx_en) begin
        st <= IDLE;
      end else if (st == IDLE) begin
        if (!s2) begin
          st  <= START;
          cnt <= '0;
        end
      end else if (baud_tick) begin
        if (!hit) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
          case (st)
            START: begin
              st   <= s2 ? IDLE : DATA;
              bidx <= '0;
            end
            DATA: begin
              sh   <= {s2, sh[7:1]};
              bidx <= bidx + 1'b1;
              if (bidx == last) st <= par_on ? PAR : STOP;
            end
            PAR: begin
              pbit <= s2;
              st   <= STOP;
            end
            default: begin
              st      <= IDLE;
              rx_data <= word;
              err_par <= pe;
              err_frm <= !s2;
              err_ovr <= full;
              full    <= 1'b1;
              if (pe || !s2 || full) rx_err <= 1'b1;
              else rx_done <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  assert_done_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
  assert_pulses_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_done && rx_err));
  assert_no_pulse_after_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_en) |-> (!rx_done && !rx_err));
  assert_buffer_moves_with_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> (rx_done || rx_err));
  assert_msb_zero_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_done || rx_err) && $past(len7)) |-> !rx_data[7]);
  assert_err_has_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> (err_par || err_frm || err_ovr));
  assert_done_clears_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> !(err_par || err_frm || err_ovr));
endmodule

// File: tb/tb_uart_rx_gated.sv
`timescale 1ns/1ps
module tb_uart_rx_gated;
  logic clk = 0, rst_n = 0, rx_en = 0, rx_in = 1, baud_tick = 0, len7 = 0, buf_read = 0;
  logic [4:0] div_val = 5'd8;
  logic [1:0] par_mode = 2'b01;
  logic [7:0] rx_data;
  logic rx_done, rx_err, err_par, err_frm, err_ovr;
  int total = 0, bad = 0, nd = 0, ne = 0, tper = 1, tc = 0;

  uart_rx_gated dut (.*);

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (tc >= tper - 1) begin tc = 0; baud_tick = 1; end
    else begin tc++; baud_tick = 0; end
  end

  always @(posedge clk) if (rst_n) begin
    if (rx_done) nd++;
    if (rx_err) ne++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(input logic v);
    rx_in = v;
    repeat (int'(div_val) * tper) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit badpar, input logic stopv);
    int nb = len7 ? 7 : 8;
    logic [7:0] m = len7 ? (d & 8'h7f) : d;
    hold_bit(1'b0);
    for (int i = 0; i < nb; i++) hold_bit(d[i]);
    if (^par_mode) hold_bit(^m ^ par_mode[1] ^ badpar);
    hold_bit(stopv);
    hold_bit(1'b1);
    hold_bit(1'b1);
  endtask

  task automatic readbuf();
    buf_read = 1; @(negedge clk); buf_read = 0;
  endtask

  task automatic frame(input logic [7:0] d, input bit badpar, input logic stopv,
                       input bit exp_ovr, input bit rd, input string req);
    int d0 = nd, e0 = ne;
    logic [7:0] m = len7 ? (d & 8'h7f) : d;
    bit epe = badpar && (^par_mode);
    bit efe = !stopv;
    bit eer = epe || efe || exp_ovr;
    send(d, badpar, stopv);
    if (eer) chk(ne == e0 + 1 && nd == d0, {req, " error pulse"}, ne - e0, 1);
    else     chk(nd == d0 + 1 && ne == e0, {req, " done pulse"}, nd - d0, 1);
    chk(rx_data == m, {req, " data"}, rx_data, m);
    chk({err_par, err_frm, err_ovr} == {epe, efe, exp_ovr}, {req, " flags"},
        {err_par, err_frm, err_ovr}, {epe, efe, exp_ovr});
    if (rd) readbuf();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d0, e0;
    logic [7:0] keep;
    repeat (3) @(negedge clk);
    chk(rx_data == 0 && {err_par, err_frm, err_ovr} == 0 && !rx_done && !rx_err,
        "R1 reset state", {rx_data, err_par, err_frm, err_ovr}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    rx_en = 1;
    repeat (4) @(negedge clk);

    // R4 R5 R6: every 8-bit character, even parity
    div_val = 8; len7 = 0; par_mode = 2'b01;
    for (int v = 0; v < 256; v++) frame(v[7:0], 0, 1, 0, 1, "R4 R5 R6 even sweep");

    // R4 R5: every 7-bit character, odd parity, high bit driven 1 must not appear
    div_val = 12; len7 = 1; par_mode = 2'b10;
    for (int v = 0; v < 128; v++) frame(v[7:0] | 8'h80, 0, 1, 0, 1, "R4 R5 short odd sweep");

    // R3 R5: longest divider, no parity
    div_val = 31; len7 = 0; par_mode = 2'b00;
    for (int v = 0; v < 64; v++) frame(8'(v * 37 + 5), 0, 1, 0, 1, "R3 R5 div31 none");

    // R5: mode 11 carries no parity bit
    div_val = 9; par_mode = 2'b11;
    for (int v = 0; v < 8; v++) frame(8'(v * 29 + 1), 0, 1, 0, 1, "R5 mode11 none");

    // R3: slow ticks, counter advances only on ticks
    tper = 3; div_val = 8; par_mode = 2'b10;
    for (int v = 0; v < 16; v++) frame(8'(v * 17), 0, 1, 0, 1, "R3 tick gating");
    tper = 1;

    // R5 R9: parity errors
    par_mode = 2'b01; frame(8'hA5, 1, 1, 0, 1, "R5 R9 even parity error");
    par_mode = 2'b10; frame(8'h3C, 1, 1, 0, 1, "R5 R9 odd parity error");
    frame(8'h3C, 0, 1, 0, 1, "R9 flags cleared by clean frame");

    // R8 R9: overrun
    frame(8'h11, 0, 1, 0, 0, "R8 first unread");
    frame(8'h22, 0, 1, 1, 1, "R8 overrun");
    frame(8'h33, 0, 1, 0, 1, "R8 after read clean");

    // R7: framing error
    frame(8'h5A, 0, 0, 0, 1, "R7 framing error");

    // R10: abort mid-frame keeps stale buffer and flags
    keep = rx_data; d0 = nd; e0 = ne;
    hold_bit(1'b0); hold_bit(1'b1); hold_bit(1'b0); hold_bit(1'b1);
    rx_en = 0;
    for (int i = 0; i < 7; i++) hold_bit(i[0]);
    hold_bit(1'b1); hold_bit(1'b1);
    chk(nd == d0 && ne == e0, "R10 no pulse after abort", nd + ne, d0 + e0);
    chk(rx_data == keep, "R10 buffer kept", rx_data, keep);
    chk({err_par, err_frm, err_ovr} == 3'b010, "R10 flags kept",
        {err_par, err_frm, err_ovr}, 3'b010);
    rx_en = 1;
    repeat (4) @(negedge clk);
    frame(8'hC3, 0, 1, 0, 1, "R10 resume");

    // R2: short glitch rejected at half-bit check
    d0 = nd; e0 = ne;
    rx_in = 0; repeat (2) @(negedge clk); rx_in = 1;
    repeat (40) @(negedge clk);
    chk(nd == d0 && ne == e0, "R2 glitch rejected", nd + ne, d0 + e0);
    frame(8'h96, 0, 1, 0, 1, "R2 frame after glitch");

    // R11: enable while line already low
    rx_en = 0; rx_in = 0;
    repeat (20) @(negedge clk);
    rx_en = 1;
    frame(8'h4B, 0, 1, 0, 1, "R11 enable while low");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule